// File: doc/BRIEF.md
# Serial ADC Startup and Polling Controller

This block sits on the host side of a serial successive-approximation converter. After reset it runs the converter's bring-up frames on its own. First comes a write of the secondary configuration register under a reserved command. Next comes a frame that loads the primary configuration and starts the first real sample. From then on it polls: it waits for the end-of-conversion line to go low and come back high, runs a 12-clock frame that returns the previous result, and starts the next conversion with the channel currently requested.

Each real result is handed to the core as a 12-bit word with a single-cycle valid strobe. The word is tagged with the channel that was requested in the frame that launched its conversion. Data shifted back during the two bring-up frames is thrown away.

The serial clock is derived from the system clock by a fixed half-period divider. A timeout on the end-of-conversion wait sets a sticky error and restarts bring-up from the first frame.

Top module: `adc_boot_poller`

## Requirements
- R1: While reset is asserted, chip select is high (inactive), the serial clock is low, the result strobe is low and the error flag is clear.
- R2: The first frame after reset sends the byte {4'b1111, cfg2Low} most significant bit first, followed by zero bits. Its length in serial clocks is set by cfg2Len: 0 gives 8 clocks, 1 gives 12, and 2 or 3 give 16. After its last falling clock edge, chip select is high for exactly one cycle.
- R3: Whenever chip select falls, the serial clock stays low for setupCyc+1 system cycles before the low half of the first bit starts. The command MSB is already on the command line during that interval.
- R4: Each serial clock half lasts HALF_DIV system cycles. The command line changes only while the serial clock is low. The returned data line is sampled at each rising serial clock edge.
- R5: The second frame sends {chanSel, cfg1Low} in 12 clocks. Neither the first nor the second frame produces a result strobe.
- R6: From the third frame on, every frame is 12 clocks long. In the cycle after its last falling edge, resValid is high for one cycle. resData then holds the 12 sampled bits (first sample in bit 11), and resChan holds the channel sent in the preceding frame.
- R7: After the second frame and after every later frame, the next frame does not start until adcEoc has been seen low and then high again.
- R8: Chip select rises after the second frame. Between later frames it stays low when csHoldLow is 1, and the next frame then starts with no setup interval. When csHoldLow is 0 it stays high for the wait and one more cycle, and the next frame then has a setup interval.
- R9: If the end-of-conversion wait lasts EOC_TIMEOUT cycles, errTimeout is set and chip select goes high. Bring-up then restarts at the first frame. errTimeout stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| setupCyc | input | 8 | Extra setup cycles after chip select falls |
| cfg2Len | input | 2 | Length code of the secondary configuration frame |
| csHoldLow | input | 1 | Keep chip select low between polling frames |
| chanSel | input | 4 | Channel address for the next conversion |
| cfg1Low | input | 4 | Low nibble of the primary configuration byte |
| cfg2Low | input | 4 | Low nibble of the secondary configuration byte |
| adcDout | input | 1 | Serial data returned by the converter |
| adcEoc | input | 1 | End of conversion, low while converting |
| adcCsN | output | 1 | Chip select to the converter, active low |
| adcSclk | output | 1 | Serial clock to the converter |
| adcDin | output | 1 | Serial command line to the converter |
| resData | output | 12 | Latest conversion result |
| resChan | output | 4 | Channel the result belongs to |
| resValid | output | 1 | One-cycle strobe for a new result |
| errTimeout | output | 1 | Sticky end-of-conversion timeout flag |

## Verification
The hardest situation to reach is a timeout that strikes in the middle of steady polling with chip select held low. The error path has to raise chip select, drop the partly built polling state and replay both bring-up frames with fresh settings, and the sticky flag must survive that replay. The stimulus reaches it by running several held-low polling frames, then leaving the end-of-conversion line high so the wait runs out. It changes the secondary frame length, follows the restart frame by frame, and only clears the flag with a later reset.

// File: rtl/adc_boot_pkg.sv
package adc_boot_pkg;
  localparam int CMD_W  = 8;
  localparam int RES_W  = 12;
  localparam int CHAN_W = 4;
  localparam int TX_W   = 16;
  localparam int BIT_W  = 5;

  typedef struct packed {
    logic load;     // load command byte and channel tag
    logic run;      // serial clock generator enabled
    logic capture;  // publish assembled result
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_SHIFT, ST_WAITLO, ST_WAITHI
  } seqState_t;

  typedef enum logic [1:0] {
    PH_CFG2, PH_CFG1, PH_RUN
  } bootPhase_t;
endpackage

// File: rtl/adc_boot_dp.sv
module adc_boot_dp
  import adc_boot_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         strobe,
  input  logic [CMD_W-1:0]  cmdByte,
  input  logic [CHAN_W-1:0] cmdChan,
  input  logic              adcDout,
  output logic              fallTick,
  output logic              adcSclk,
  output logic              adcDin,
  output logic [RES_W-1:0]  resData,
  output logic [CHAN_W-1:0] resChan,
  output logic              resValid
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  logic [DIV_W-1:0]  divCnt;
  logic              sclkQ;
  logic [TX_W-1:0]   txReg;
  logic [RES_W-1:0]  rxReg;
  logic [CHAN_W-1:0] sentChan, convChan;
  logic              halfDone, riseTick;

  assign halfDone = strobe.run && (divCnt == DIV_LAST);
  assign fallTick = halfDone && sclkQ;
  assign riseTick = halfDone && !sclkQ;
  assign adcSclk  = sclkQ;
  assign adcDin   = txReg[TX_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divCnt <= '0;
      sclkQ  <= 1'b0;
    end else if (!strobe.run) begin
      divCnt <= '0;
      sclkQ  <= 1'b0;
    end else if (halfDone) begin
      divCnt <= '0;
      sclkQ  <= ~sclkQ;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txReg    <= '0;
      rxReg    <= '0;
      sentChan <= '0;
      convChan <= '0;
    end else begin
      if (strobe.load) begin
        txReg    <= {cmdByte, {(TX_W-CMD_W){1'b0}}};
        sentChan <= cmdChan;
        convChan <= sentChan;
      end else if (fallTick) begin
        txReg <= {txReg[TX_W-2:0], 1'b0};
      end
      if (riseTick) rxReg <= {rxReg[RES_W-2:0], adcDout};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resValid <= 1'b0;
      resData  <= '0;
      resChan  <= '0;
    end else begin
      resValid <= strobe.capture;
      if (strobe.capture) begin
        resData <= rxReg;
        resChan <= convChan;
      end
    end
  end
endmodule

// File: rtl/adc_boot_ctrl.sv
module adc_boot_ctrl
  import adc_boot_pkg::*;
#(
  parameter int EOC_TIMEOUT = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fallTick,
  input  logic              adcEoc,
  input  logic [7:0]        setupCyc,
  input  logic [1:0]        cfg2Len,
  input  logic              csHoldLow,
  input  logic [CHAN_W-1:0] chanSel,
  input  logic [3:0]        cfg1Low,
  input  logic [3:0]        cfg2Low,
  output dpStrobe_t         strobe,
  output logic [CMD_W-1:0]  cmdByte,
  output logic [CHAN_W-1:0] cmdChan,
  output logic              adcCsN,
  output logic              errTimeout
);
  localparam int TMO_W = (EOC_TIMEOUT > 2) ? $clog2(EOC_TIMEOUT) : 1;
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(EOC_TIMEOUT - 1);
  localparam logic [3:0] CFG2_CODE = 4'b1111;

  seqState_t        state;
  bootPhase_t       phase;
  logic [7:0]       setCnt;
  logic [BIT_W-1:0] bitCnt, lenLast;
  logic [TMO_W-1:0] tmoCnt;
  logic             frameEnd;

  always_comb begin
    if (phase == PH_CFG2) begin
      case (cfg2Len)
        2'd0:    lenLast = BIT_W'(7);
        2'd1:    lenLast = BIT_W'(11);
        default: lenLast = BIT_W'(15);
      endcase
    end else begin
      lenLast = BIT_W'(RES_W - 1);
    end
  end

  assign frameEnd       = (state == ST_SHIFT) && fallTick && (bitCnt == lenLast);
  assign cmdByte        = (phase == PH_CFG2) ? {CFG2_CODE, cfg2Low} : {chanSel, cfg1Low};
  assign cmdChan        = chanSel;
  assign strobe.load    = (state == ST_IDLE);
  assign strobe.run     = (state == ST_SHIFT);
  assign strobe.capture = frameEnd && (phase == PH_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      phase      <= PH_CFG2;
      adcCsN     <= 1'b1;
      errTimeout <= 1'b0;
      setCnt     <= '0;
      bitCnt     <= '0;
      tmoCnt     <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          adcCsN <= 1'b0;
          setCnt <= '0;
          bitCnt <= '0;
          state  <= adcCsN ? ST_SETUP : ST_SHIFT;
        end
        ST_SETUP: begin
          if (setCnt == setupCyc) state <= ST_SHIFT;
          else setCnt <= setCnt + 1'b1;
        end
        ST_SHIFT: begin
          if (frameEnd) begin
            tmoCnt <= '0;
            case (phase)
              PH_CFG2: begin
                phase  <= PH_CFG1;
                adcCsN <= 1'b1;
                state  <= ST_IDLE;
              end
              PH_CFG1: begin
                phase  <= PH_RUN;
                adcCsN <= 1'b1;
                state  <= ST_WAITLO;
              end
              default: begin
                adcCsN <= ~csHoldLow;
                state  <= ST_WAITLO;
              end
            endcase
          end else if (fallTick) begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_WAITLO, ST_WAITHI: begin
          if (tmoCnt == TMO_LAST) begin
            errTimeout <= 1'b1;
            phase      <= PH_CFG2;
            adcCsN     <= 1'b1;
            state      <= ST_IDLE;
          end else begin
            tmoCnt <= tmoCnt + 1'b1;
            if (state == ST_WAITLO && !adcEoc) state <= ST_WAITHI;
            if (state == ST_WAITHI && adcEoc)  state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_boot_poller.sv
module adc_boot_poller
  import adc_boot_pkg::*;
#(
  parameter int HALF_DIV    = 4,
  parameter int EOC_TIMEOUT = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  setupCyc,
  input  logic [1:0]  cfg2Len,
  input  logic        csHoldLow,
  input  logic [3:0]  chanSel,
  input  logic [3:0]  cfg1Low,
  input  logic [3:0]  cfg2Low,
  input  logic        adcDout,
  input  logic        adcEoc,
  output logic        adcCsN,
  output logic        adcSclk,
  output logic        adcDin,
  output logic [11:0] resData,
  output logic [3:0]  resChan,
  output logic        resValid,
  output logic        errTimeout
);
  dpStrobe_t         strobe;
  logic [CMD_W-1:0]  cmdByte;
  logic [CHAN_W-1:0] cmdChan;
  logic              fallTick;

  adc_boot_ctrl #(.EOC_TIMEOUT(EOC_TIMEOUT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fallTick(fallTick), .adcEoc(adcEoc),
    .setupCyc(setupCyc), .cfg2Len(cfg2Len), .csHoldLow(csHoldLow),
    .chanSel(chanSel), .cfg1Low(cfg1Low), .cfg2Low(cfg2Low),
    .strobe(strobe), .cmdByte(cmdByte), .cmdChan(cmdChan),
    .adcCsN(adcCsN), .errTimeout(errTimeout)
  );

  adc_boot_dp #(.HALF_DIV(HALF_DIV)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .cmdByte(cmdByte),
    .cmdChan(cmdChan), .adcDout(adcDout), .fallTick(fallTick),
    .adcSclk(adcSclk), .adcDin(adcDin), .resData(resData),
    .resChan(resChan), .resValid(resValid)
  );
endmodule

// File: rtl/adc_boot_poller_chk.sv
module adc_boot_poller_chk (
  input logic clk,
  input logic rst_n,
  input logic adcCsN,
  input logic adcSclk,
  input logic adcDin,
  input logic resValid,
  input logic errTimeout
);
  AST_CLOCK_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n) adcCsN |-> !adcSclk); // R8
  AST_DIN_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n) adcSclk |-> $stable(adcDin)); // R4
  AST_SETUP_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n) $fell(adcCsN) |=> !adcSclk); // R3
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) resValid |=> !resValid); // R6
  AST_VALID_CLOCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n) resValid |-> !adcSclk); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) errTimeout |=> errTimeout); // R9
endmodule

bind adc_boot_poller adc_boot_poller_chk u_chk (
  .clk(clk), .rst_n(rst_n), .adcCsN(adcCsN), .adcSclk(adcSclk),
  .adcDin(adcDin), .resValid(resValid), .errTimeout(errTimeout)
);

// File: tb/adc_boot_poller_test.sv
module adc_boot_poller_test;
  localparam int H   = 2;
  localparam int TMO = 40;

  logic clk = 1'b0, rst_n = 1'b0, adcDout = 1'b0, adcEoc = 1'b1, csHoldLow = 1'b0;
  logic [7:0]  setupCyc = 8'd3;
  logic [1:0]  cfg2Len = 2'd0;
  logic [3:0]  chanSel = 4'h2, cfg1Low = 4'h9, cfg2Low = 4'h6;
  logic        adcCsN, adcSclk, adcDin, resValid, errTimeout;
  logic [11:0] resData;
  logic [3:0]  resChan;

  int    checks = 0, fails = 0;
  bit    mErr = 1'b0, finished = 1'b0;
  logic [3:0] prevChan;
  string tag = "R1 reset";

  adc_boot_poller #(.HALF_DIV(H), .EOC_TIMEOUT(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .setupCyc(setupCyc), .cfg2Len(cfg2Len),
    .csHoldLow(csHoldLow), .chanSel(chanSel), .cfg1Low(cfg1Low), .cfg2Low(cfg2Low),
    .adcDout(adcDout), .adcEoc(adcEoc), .adcCsN(adcCsN), .adcSclk(adcSclk),
    .adcDin(adcDin), .resData(resData), .resChan(resChan), .resValid(resValid),
    .errTimeout(errTimeout)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // One system cycle of the reference timeline, checked mid-cycle.
  task automatic cyc(input logic eCs, input logic eSclk, input bit dinCare, input logic eDin,
                     input logic eValid, input logic [11:0] eData, input logic [3:0] eChan);
    @(negedge clk);
    chk(adcCsN === eCs, {tag, " chip select"}, int'(adcCsN), int'(eCs));
    chk(adcSclk === eSclk, {tag, " R4 serial clock"}, int'(adcSclk), int'(eSclk));
    chk(errTimeout === mErr, {tag, " R9 error flag"}, int'(errTimeout), int'(mErr));
    chk(resValid === eValid, {tag, " R6 result strobe"}, int'(resValid), int'(eValid));
    if (dinCare) chk(adcDin === eDin, {tag, " command bit"}, int'(adcDin), int'(eDin));
    if (eValid) begin
      chk(resData === eData, {tag, " R6 result word"}, int'(resData), int'(eData));
      chk(resChan === eChan, {tag, " R6 channel tag"}, int'(resChan), int'(eChan));
    end
  endtask

  task automatic setupPh(input logic [7:0] cmd);
    string old = tag;
    tag = "R3 setup";
    repeat (int'(setupCyc) + 1) cyc(1'b0, 1'b0, 1'b1, cmd[7], 1'b0, '0, '0);
    tag = old;
  endtask

  task automatic shiftPh(input int len, input logic [7:0] cmd, input logic [11:0] word);
    for (int k = 0; k < len; k++) begin
      logic b, rb;
      b  = (k < 8)  ? cmd[7-k]   : 1'b0;
      rb = (k < 12) ? word[11-k] : 1'b0;
      for (int h = 0; h < H; h++) begin
        cyc(1'b0, 1'b0, 1'b1, b, 1'b0, '0, '0);
        adcDout = rb;
      end
      for (int h = 0; h < H; h++) cyc(1'b0, 1'b1, 1'b1, b, 1'b0, '0, '0);
    end
  endtask

  task automatic waitPh(input logic eCs, input logic eValid, input logic [11:0] data,
                        input logic [3:0] ch, input int d1, input int d2);
    tag = "R6 result";
    cyc(eCs, 1'b0, 1'b0, 1'b0, eValid, data, ch);
    chanSel = 4'(chanSel + 4'd5);
    tag = "R7 eoc wait";
    repeat (d1) cyc(eCs, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
    adcEoc = 1'b0;
    repeat (d2 + 1) cyc(eCs, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
    adcEoc = 1'b1;
    tag = "R8 idle";
    cyc(eCs, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic timeoutPh(input logic eCs, input logic [11:0] data, input logic [3:0] ch);
    tag = "R6 result";
    cyc(eCs, 1'b0, 1'b0, 1'b0, 1'b1, data, ch);
    tag = "R9 timeout";
    repeat (TMO - 1) cyc(eCs, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
    mErr = 1'b1;
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic doReset();
    rst_n = 1'b0;
    adcEoc = 1'b1;
    mErr = 1'b0;
    repeat (2) @(negedge clk);
    tag = "R1 reset";
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
    rst_n = 1'b1;
  endtask

  task automatic runSession(input int nNorm, input bit endTimeout, input logic [11:0] seed);
    logic [7:0]  cmd;
    logic [11:0] word;
    logic [3:0]  expChan;
    int len0;
    // first frame: secondary configuration write
    cmd  = {4'b1111, cfg2Low};
    len0 = (cfg2Len == 2'd0) ? 8 : (cfg2Len == 2'd1) ? 12 : 16;
    tag  = "R2 cfg2 frame";
    setupPh(cmd);
    shiftPh(len0, cmd, 12'hFFF);
    tag = "R2 gap";
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
    // second frame: primary configuration, first conversion
    cmd = {chanSel, cfg1Low};
    tag = "R5 cfg1 frame";
    setupPh(cmd);
    shiftPh(12, cmd, 12'h5A5);
    prevChan = chanSel;
    waitPh(1'b1, 1'b0, '0, '0, 1, 2);
    for (int i = 0; i < nNorm; i++) begin
      cmd  = {chanSel, cfg1Low};
      word = 12'(seed + 12'(i) * 12'h1F7);
      tag  = "R6 data frame";
      if (!(csHoldLow && i > 0)) setupPh(cmd);
      shiftPh(12, cmd, word);
      expChan  = prevChan;
      prevChan = chanSel;
      if (endTimeout && i == nNorm - 1) timeoutPh(~csHoldLow, word, expChan);
      else waitPh(~csHoldLow, 1'b1, word, expChan, i % 3, (i * 2) % 5);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 R2 R3 R5 R6 R7: toggling chip select, 8-clock secondary frame
    doReset();
    runSession(4, 1'b0, 12'hA53);
    // R8 held chip select, no setup, 12-clock secondary frame, ending in R9 timeout
    setupCyc = 8'd0; cfg2Len = 2'd1; csHoldLow = 1'b1; chanSel = 4'h7;
    doReset();
    runSession(5, 1'b1, 12'h0F1);
    // restart after timeout with a 16-clock secondary frame, flag still set
    cfg2Len = 2'd2; cfg2Low = 4'hC; setupCyc = 8'd5;
    runSession(3, 1'b0, 12'hE3C);
    // reset clears the flag; code 3 also selects 16 clocks
    cfg2Len = 2'd3; csHoldLow = 1'b0; setupCyc = 8'd1; cfg1Low = 4'h4;
    doReset();
    runSession(2, 1'b0, 12'h801);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule